// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware events for profiling. It has four 32-bit counters. Each counter takes its input from one of 128 single-cycle event lines, and software picks that line separately for each counter. Counting is controlled at three levels. A facility enable and a global freeze stop every counter at once. Per-counter freeze bits stop one counter while the processor is in user mode, while it is in supervisor mode, or under plain software command. An armed freeze-on-event mode stops every counter in hardware as soon as an enabled overflow appears.

Software reaches the block through a simple register port. The port carries a privilege input. Reads return data combinationally on the same cycle. Writes take effect at the clock edge. Only supervisor mode may write. Every register also appears a second time, at an address with bit 4 set, as a read-only mirror. User code can read the counters and controls through these mirrors.

A counter is in the overflow state while its top bit is 1. The single interrupt request is a level. It is high exactly while four things hold together: some counter is overflowed with its overflow signalling enabled, the global overflow-exception enable is set, the facility is enabled, and the external interrupt-enable input is high.

Top module: `pmu_evt_monitor`

## Requirements
- R1: After synchronous reset, every register reads 0 at both its base and its mirror address, and `irq` and `acc_err` are low.
- R2: Local control B bits [6:0] select the event line for a counter. The counter adds 1 at each clock edge where the selected line is high and the counter may run. All other event lines have no effect on it.
- R3: Global control bit 3 is the facility enable. While it is 0, no counter changes except by a software write, and `irq` stays low.
- R4: Global control bit 0 freezes all counters. Clearing it lets them count again.
- R5: Local control A bit 0 freezes its counter while `priv_super` is 0. Bit 1 freezes it while `priv_super` is 1. Bit 2 freezes it regardless of mode.
- R6: `irq` equals the AND of three terms: some counter has its top bit set together with its overflow-signal enable (local A bit 3); the global overflow-exception enable (global bit 2) and the facility enable are both set; and `ext_int_en` is high. It is a combinational level, so it falls in the same cycle that any term falls.
- R7: A counter stays in the overflow state (top bit 1) until software writes it with a value whose top bit is 0. Counting saturates at all ones instead of wrapping.
- R8: When global bit 1 (freeze-on-event) and the facility enable are set and an enabled overflow is present, hardware sets the global freeze bit at the next edge. After that edge the counters advance no further.
- R9: A software write to a counter wins over an increment in the same cycle. The written value is read back exactly after that edge.
- R10: Writes take effect only when `priv_super` is 1 and address bit 4 is 0. Any other write leaves every register unchanged and drives `acc_err` high for exactly the one cycle after the write edge.
- R11: Address map, with the low four bits as follows: 0 is global control, 4 to 7 are counters 0 to 3, 8+2i is local control A of counter i, and 9+2i is local control B of counter i. Setting bit 4 gives the read-only mirror of the same register. Local A keeps 4 bits and local B keeps 7 bits. The bits that are not kept read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 128 | Event pulse lines |
| priv_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| ext_int_en | input | 1 | External interrupt enable gating the request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address; bit 4 selects the read-only mirror |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |
| acc_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench sweeps all 128 select values on all four counters at once. Each counter gets a different select and a different expected count, and the unselected lines are driven high as decoys. A mux built with the wrong index or width therefore gives a wrong count. All sixteen combinations of the interrupt terms are tried, and a missing gating term would raise `irq` where it must stay low. Boundary cases cover these faults:
- a counter that wraps past all ones would lose its overflow state;
- a freeze-on-event path with an extra or missing stage would stop counting one edge late or early;
- a write that loses to an increment would read back one too high;
- a user-mode or mirror write that is not rejected would corrupt a register and give no error pulse.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // Register map is fixed at four counters
    localparam int NUM_CTR = 4;

    // Global control, bit 0 = freeze, 1 = freeze-on-event, 2 = overflow exception enable, 3 = facility enable
    typedef struct packed {
        logic fe;
        logic oie;
        logic foe;
        logic frz;
    } gctl_t;

    // Local control A, bit 0 = user freeze, 1 = supervisor freeze, 2 = software freeze, 3 = overflow signal enable
    typedef struct packed {
        logic ovf_en;
        logic frz_sw;
        logic frz_sup;
        logic frz_usr;
    } lctla_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_GCTL,
        RK_CTR,
        RK_LCA,
        RK_LCB
    } reg_kind_e;

    function automatic reg_kind_e decode_kind(input logic [3:0] loc);
        if (loc == 4'd0)       return RK_GCTL;
        else if (loc[3])       return loc[0] ? RK_LCB : RK_LCA;
        else if (loc[2])       return RK_CTR;
        else                   return RK_NONE;
    endfunction

    function automatic logic [1:0] decode_idx(input logic [3:0] loc);
        return loc[3] ? loc[2:1] : loc[1:0];
    endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 128,
    localparam int SEL_W  = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    input  logic               run,
    input  logic               wr,
    input  logic [CTR_W-1:0]   wdata,
    output logic [CTR_W-1:0]   cnt,
    output logic               ovf
);

    logic [CTR_W-1:0] cnt_q;
    logic             hit;
    logic             step;

    assign hit  = evt[sel];
    assign step = run && hit && !(&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wr)   cnt_q <= wdata;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
    assign ovf = cnt_q[CTR_W-1];

    // R9
    sw_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt == $past(wdata)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !wr) |=> ovf);

endmodule

// File: rtl/pmu_irq_gate.sv
module pmu_irq_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ovf,
    input  logic [N-1:0] ovf_en,
    input  logic         oie,
    input  logic         fe,
    input  logic         ext_ie,
    output logic         any_ovf_en,
    output logic         irq
);

    assign any_ovf_en = |(ovf & ovf_en);
    assign irq        = any_ovf_en && oie && fe && ext_ie;

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ext_ie && oie && fe && (ovf != '0)));

endmodule

// File: rtl/pmu_evt_monitor.sv
module pmu_evt_monitor
    import pmu_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 128,
    parameter int ADDR_W  = 5,
    localparam int SEL_W  = $clog2(NUM_EVT),
    localparam int LA_W   = $bits(lctla_t),
    localparam int GC_W   = $bits(gctl_t)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               priv_super,
    input  logic               ext_int_en,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CTR_W-1:0]   reg_wdata,
    output logic [CTR_W-1:0]   reg_rdata,
    output logic               irq,
    output logic               acc_err
);

    gctl_t             gctl_q;
    lctla_t            la_q [NUM_CTR];
    logic [SEL_W-1:0]  lb_q [NUM_CTR];
    logic [CTR_W-1:0]  cnt  [NUM_CTR];
    logic [NUM_CTR-1:0] ovf_v, ovf_en_v, run_v, ctr_wr;
    logic              any_ovf_en;
    logic              acc_err_q;

    logic              mirror;
    logic [3:0]        loc;
    reg_kind_e         kind;
    logic [1:0]        idx;
    logic              wr_ok, bad_wr, gctl_wr, hw_frz_set;

    assign mirror  = reg_addr[ADDR_W-1];
    assign loc     = reg_addr[3:0];
    assign kind    = decode_kind(loc);
    assign idx     = decode_idx(loc);
    assign wr_ok   = reg_wr && priv_super && !mirror;
    assign bad_wr  = reg_wr && !(priv_super && !mirror);
    assign gctl_wr = wr_ok && (kind == RK_GCTL);

    assign hw_frz_set = gctl_q.foe && gctl_q.fe && any_ovf_en;

    // Global control: software write first, hardware freeze-on-event otherwise
    always_ff @(posedge clk) begin
        if (rst)             gctl_q <= '0;
        else if (gctl_wr)    gctl_q <= gctl_t'(reg_wdata[GC_W-1:0]);
        else if (hw_frz_set) gctl_q.frz <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_err_q <= 1'b0;
        else     acc_err_q <= bad_wr;
    end
    assign acc_err = acc_err_q;

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            logic la_wr, lb_wr;
            assign la_wr     = wr_ok && (kind == RK_LCA) && (idx == 2'(i));
            assign lb_wr     = wr_ok && (kind == RK_LCB) && (idx == 2'(i));
            assign ctr_wr[i] = wr_ok && (kind == RK_CTR) && (idx == 2'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    la_q[i] <= '0;
                    lb_q[i] <= '0;
                end else begin
                    if (la_wr) la_q[i] <= lctla_t'(reg_wdata[LA_W-1:0]);
                    if (lb_wr) lb_q[i] <= reg_wdata[SEL_W-1:0];
                end
            end

            assign run_v[i] = gctl_q.fe && !gctl_q.frz && !la_q[i].frz_sw
                            && !(la_q[i].frz_usr && !priv_super)
                            && !(la_q[i].frz_sup &&  priv_super);
            assign ovf_en_v[i] = la_q[i].ovf_en;

            pmu_counter #(
                .CTR_W   (CTR_W),
                .NUM_EVT (NUM_EVT)
            ) u_ctr (
                .clk   (clk),
                .rst   (rst),
                .evt   (evt_in),
                .sel   (lb_q[i]),
                .run   (run_v[i]),
                .wr    (ctr_wr[i]),
                .wdata (reg_wdata),
                .cnt   (cnt[i]),
                .ovf   (ovf_v[i])
            );

            // R3
            fe_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!gctl_q.fe && !ctr_wr[i]) |=> $stable(cnt[i]));

            // R4
            gfrz_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (gctl_q.frz && !ctr_wr[i]) |=> $stable(cnt[i]));
        end
    endgenerate

    pmu_irq_gate #(.N(NUM_CTR)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ovf        (ovf_v),
        .ovf_en     (ovf_en_v),
        .oie        (gctl_q.oie),
        .fe         (gctl_q.fe),
        .ext_ie     (ext_int_en),
        .any_ovf_en (any_ovf_en),
        .irq        (irq)
    );

    // Read mux; mirror addresses return the same contents
    always_comb begin
        reg_rdata = '0;
        case (kind)
            RK_GCTL: reg_rdata = CTR_W'(gctl_q);
            RK_CTR:  reg_rdata = cnt[idx];
            RK_LCA:  reg_rdata = CTR_W'(la_q[idx]);
            RK_LCB:  reg_rdata = CTR_W'(lb_q[idx]);
            default: reg_rdata = '0;
        endcase
    end

    // R10
    bad_wr_err_chk: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> acc_err);

    // R10
    bad_wr_gctl_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_wr && !hw_frz_set) |=> $stable(gctl_q));

    // R8
    foe_frz_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_frz_set && !gctl_wr) |=> gctl_q.frz);

endmodule

// File: tb/sim_pmu_evt_monitor.sv
module sim_pmu_evt_monitor;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] evt = '0;
    logic         priv_super = 1'b1;
    logic         ext_int_en = 1'b0;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;
    logic         acc_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    pmu_evt_monitor u0 (
        .clk        (clk),
        .rst        (rst),
        .evt_in     (evt),
        .priv_super (priv_super),
        .ext_int_en (ext_int_en),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .acc_err    (acc_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, vm;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a >= 4) begin
                rchk("R1 base", 5'(a), 32'd0);
                rchk("R1 mirror", 5'(a + 16), 32'd0);
            end
        end
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 acc_err", {31'd0, acc_err}, 32'd0);

        // R2 exhaustive select sweep, four counters at once
        wr(0, 32'h8);
        for (int k = 0; k < 128; k++) begin
            int s [4];
            logic [127:0] vec;
            for (int i = 0; i < 4; i++) begin
                s[i] = (k + 37 * i) % 128;
                wr(5'(4 + i), 32'd0);
                wr(5'(9 + 2 * i), 32'(s[i]));
            end
            vec = '1;
            for (int i = 0; i < 4; i++) vec[s[i]] = 1'b0;
            @(negedge clk); evt = vec;
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                vec = '0;
                for (int i = c; i < 4; i++) vec[s[i]] = 1'b1;
                @(negedge clk); evt = vec;
            end
            @(negedge clk); evt = '0;
            for (int i = 0; i < 4; i++) rchk("R2 select count", 5'(4 + i), 32'(i + 1));
        end

        // R3 facility disabled: no counting, no irq
        wr(0, 32'h4);
        wr(8, 32'h8);
        wr(4, 32'h8000_0000);
        wr(5, 32'd5);
        wr(9, 32'd3); wr(11, 32'd3);
        ext_int_en = 1'b1;
        @(negedge clk); evt = '1;
        repeat (3) @(negedge clk);
        evt = '0;
        rchk("R3 hold c0", 4, 32'h8000_0000);
        rchk("R3 hold c1", 5, 32'd5);
        chk("R3 irq low", {31'd0, irq}, 32'd0);
        ext_int_en = 1'b0;
        wr(8, 32'h0);

        // R4 global freeze then release
        wr(0, 32'h9);
        wr(5, 32'd0);
        @(negedge clk); evt[3] = 1'b1;
        repeat (3) @(negedge clk);
        evt = '0;
        rchk("R4 frozen", 5, 32'd0);
        wr(0, 32'h8);
        @(negedge clk); evt[3] = 1'b1;
        repeat (3) @(negedge clk);
        evt = '0;
        rchk("R4 released", 5, 32'd3);

        // R5 local freezes by mode
        for (int i = 0; i < 4; i++) begin
            wr(5'(4 + i), 32'd0);
            wr(5'(9 + 2 * i), 32'(10 + i));
            wr(5'(8 + 2 * i), (i < 3) ? (32'd1 << i) : 32'd0);
        end
        @(negedge clk); priv_super = 1'b0; evt = '1;
        @(negedge clk);
        @(negedge clk); priv_super = 1'b1;
        repeat (3) @(negedge clk);
        evt = '0;
        rchk("R5 user-freeze counter", 4, 32'd3);
        rchk("R5 super-freeze counter", 5, 32'd2);
        rchk("R5 sw-freeze counter", 6, 32'd0);
        rchk("R5 free counter", 7, 32'd5);
        for (int i = 0; i < 4; i++) wr(5'(8 + 2 * i), 32'd0);

        // R6 all sixteen gating combinations
        for (int m = 0; m < 16; m++) begin
            wr(4, m[0] ? 32'h8000_0000 : 32'h1);
            wr(8, m[1] ? 32'h8 : 32'h0);
            wr(0, m[2] ? 32'hC : 32'h8);
            @(negedge clk); ext_int_en = m[3];
            #1;
            chk("R6 irq gating", {31'd0, irq}, {31'd0, (m == 15)});
        end
        // R6 drop in same cycle
        @(negedge clk); ext_int_en = 1'b0;
        #1;
        chk("R6 same-cycle drop", {31'd0, irq}, 32'd0);

        // R7 saturation and sticky overflow
        ext_int_en = 1'b1;
        wr(9, 32'd20);
        wr(4, 32'hFFFF_FFFE);
        @(negedge clk); evt[20] = 1'b1;
        repeat (4) @(negedge clk);
        evt = '0;
        rchk("R7 saturate", 4, 32'hFFFF_FFFF);
        chk("R7 irq held", {31'd0, irq}, 32'd1);
        wr(4, 32'h3);
        rchk("R7 cleared value", 4, 32'h3);
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);
        ext_int_en = 1'b0;

        // R8 freeze on event
        wr(0, 32'hA);
        wr(8, 32'h8);
        wr(9, 32'd5); wr(11, 32'd5);
        wr(5, 32'd0);
        wr(4, 32'h7FFF_FFFF);
        @(negedge clk); evt[5] = 1'b1;
        repeat (5) @(negedge clk);
        evt = '0;
        rchk("R8 c0 one step past overflow", 4, 32'h8000_0001);
        rchk("R8 c1 frozen together", 5, 32'd2);
        rchk("R8 freeze bit set", 0, 32'hB);
        wr(8, 32'h0);
        wr(0, 32'h8);

        // R9 write beats increment
        wr(9, 32'd6);
        @(negedge clk); evt[6] = 1'b1;
        wr(4, 32'd100);
        rchk("R9 write wins", 4, 32'd100);
        @(negedge clk);
        rchk("R9 counts after", 4, 32'd101);
        evt = '0;

        // R10 rejected writes
        wr(0, 32'h0);
        wr(4, 32'h55);
        @(negedge clk);
        priv_super = 1'b0; reg_wr = 1'b1; reg_addr = 4; reg_wdata = 32'h7;
        @(negedge clk);
        reg_wr = 1'b0; priv_super = 1'b1;
        chk("R10 user write err pulse", {31'd0, acc_err}, 32'd1);
        rchk("R10 user write ignored", 4, 32'h55);
        @(negedge clk);
        chk("R10 err one cycle", {31'd0, acc_err}, 32'd0);
        wr(20, 32'h9);
        chk("R10 mirror write err pulse", {31'd0, acc_err}, 32'd1);
        rchk("R10 mirror write ignored", 4, 32'h55);
        @(negedge clk);
        priv_super = 1'b0; reg_wr = 1'b1; reg_addr = 0; reg_wdata = 32'hF;
        @(negedge clk);
        reg_wr = 1'b0; priv_super = 1'b1;
        rchk("R10 user gctl ignored", 0, 32'h0);

        // R11 map, field widths and mirrors
        for (int i = 0; i < 4; i++) begin
            wr(5'(4 + i), 32'h1000 + 32'(i));
            wr(5'(8 + 2 * i), 32'hFFFF_FFF0 | 32'(i + 1));
            wr(5'(9 + 2 * i), 32'hFFFF_FF00 | 32'(i * 3));
        end
        for (int i = 0; i < 4; i++) begin
            rchk("R11 counter", 5'(4 + i), 32'h1000 + 32'(i));
            rchk("R11 local A width", 5'(8 + 2 * i), 32'(i + 1));
            rchk("R11 local B width", 5'(9 + 2 * i), 32'(i * 3));
        end
        for (int a = 0; a < 16; a++) begin
            rd(5'(a), v);
            rd(5'(a + 16), vm);
            chk("R11 mirror equals base", vm, v);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule